// File: doc/BRIEF.md
# MDIO management frame engine

This block is the management-side master for an Ethernet PHY. Software places a complete 32-bit management frame (start, opcode, PHY address, register number, turnaround and data) into one frame register. The block then shifts that frame out on the MDC/MDIO pair. A preamble of 32 ones goes first. On a read frame, the block releases the data line from the turnaround onward and shifts the PHY's 16 reply bits into the low half of the same register.

The MDC rate comes from a divider field in a speed register, which software normally loads with the system clock in MHz divided by 5. A finished frame raises a done event, and software clears it by writing 1. A self-clearing soft-reset bit aborts any frame in flight and returns every register to zero. MDIO is presented as a data-out/output-enable pair plus a data-in, so the pad tri-state sits outside the block.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset, all four registers read 0 (control at address 0, event at 1, speed at 2, frame at 3), and `mdc` and `mdio_oe` are 0.
- R2: The divider field sits in speed register bits DIV_W:1 and reads back in that position. During a frame, MDC toggles every `field` system clocks, so one MDC period is 2 × field clocks. Outside a frame, MDC stays low.
- R3: Each frame first drives 32 ones on MDIO and then the frame bits, bit 31 first. MDIO changes only while MDC is low, and each bit is valid at MDC's rising edge. A frame whose bits 29:28 are not 10 (a write, for example) drives all 64 bits.
- R4: A frame with bits 29:28 = 10 is a read. MDIO is released for the last 18 bit times (frame bits 17:0). The line is sampled at each MDC rising edge during the 16 data bit times, and the result goes MSB first into frame bits 15:0. Frame bits 31:16 keep their value.
- R5: Event register bit 0 becomes 1 once a frame finishes. Writing 1 to it clears it, and writing 0 leaves it set.
- R6: Control bit 1 reads 1 while a frame is in progress. Writes to the frame register or the speed register during a frame are ignored.
- R7: With a divider field of 0, a frame-register write stores the word but starts no frame, and MDC stays low.
- R8: Writing 1 to control bit 0 starts a soft reset. The bit reads 1 for RST_LEN clocks and then clears itself. The reset aborts any frame without raising the done event and clears all registers.
- R9: Writing all ones to the event register clears every pending event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 event, 2 speed, 3 frame |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The bench builds the block with DIV_W = 6 and RST_LEN = 4. Divider fields of 1 and 3 are used, which covers both the fastest MDC and a multi-clock half period. A whole 64-bit frame then fits in a few hundred clocks, so every bit time of write and read frames is captured and compared. The short reset length lets the bench watch the soft-reset bit rise and clear, and confirm that an aborted frame leaves no event behind.

// File: rtl/mdio_pkg.sv
// Shared constants for the MDIO management frame engine.
// Assumes a 32-bit frame word and a 32-bit all-ones preamble.
package mdio_pkg;
    localparam int FRAME_W   = 32;
    localparam int PRE_BITS  = 32;
    localparam int SEQ_BITS  = PRE_BITS + FRAME_W;
    localparam int IDX_W     = $clog2(SEQ_BITS);
    localparam int DATA_W    = 16;
    localparam int TA_IDX    = SEQ_BITS - DATA_W - 2;
    localparam int DATA_IDX  = SEQ_BITS - DATA_W;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_EVT   = 2'd1;
    localparam logic [1:0] ADDR_SPEED = 2'd2;
    localparam logic [1:0] ADDR_FRAME = 2'd3;

    localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_clk_gen.sv
// MDC generator: while run is high, toggles mdc every div system clocks
// and flags the clock before each rising and falling MDC edge.
// Assumes div is non-zero and stable while run is high.
module mdio_clk_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = run && (cnt_q == div - 1'b1);
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    // Half-period counter and MDC toggle; idle low when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_shifter.sv
// Bit engine: sends preamble plus frame, one bit per MDC period, updating
// MDIO on MDC falling edges and, for reads, sampling on rising edges.
// Assumes rise/fall strobes from mdio_clk_gen and that start only arrives when idle.
module mdio_frame_shifter
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               rise,
    input  logic               fall,
    input  logic               mdio_i,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data,
    output logic               mdio_o,
    output logic               mdio_oe
);
    logic [FRAME_W-1:0] fr_q;
    logic [IDX_W-1:0]   idx_q;
    logic               rd_q;
    logic [IDX_W-1:0]   idx_nx;

    assign idx_nx = idx_q + 1'b1;

    function automatic logic seq_bit(input logic [IDX_W-1:0] i, input logic [FRAME_W-1:0] f);
        if (i < IDX_W'(PRE_BITS)) return 1'b1;
        return f[~i[4:0]];
    endfunction

    // Sequencer: launch, per-fall bit advance, completion and abort.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            idx_q   <= '0;
            fr_q    <= '0;
            rd_q    <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy    <= 1'b1;
                idx_q   <= '0;
                fr_q    <= frame_in;
                rd_q    <= (frame_in[29:28] == OP_READ);
                mdio_o  <= 1'b1;
                mdio_oe <= 1'b1;
            end else if (busy && fall) begin
                if (idx_q == IDX_W'(SEQ_BITS - 1)) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end else begin
                    idx_q   <= idx_nx;
                    mdio_o  <= seq_bit(idx_nx, fr_q);
                    mdio_oe <= !(rd_q && idx_nx >= IDX_W'(TA_IDX));
                end
            end
        end
    end

    // Read capture: shift in the PHY data bits on MDC rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (busy && rise && rd_q && idx_q >= IDX_W'(DATA_IDX)) begin
            rd_data <= {rd_data[DATA_W-2:0], mdio_i};
        end
    end

    // R4: the line stays released for the whole data phase of a read.
    a_r4_released_in_data: assert property (@(posedge clk) disable iff (!rst_n || abort)
        (busy && rd_q && idx_q >= IDX_W'(DATA_IDX) && $stable(idx_q)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_engine.sv
// Register front end of the MDIO master: control, event, speed and frame
// registers, soft reset, and the hookup of MDC generator and bit engine.
// Assumes a single-cycle write strobe and combinational read-back.
module mdio_mgmt_engine
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 6,
    parameter int RST_LEN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int RC_W = $clog2(RST_LEN + 1);

    logic [FRAME_W-1:0] frame_q;
    logic [DIV_W-1:0]   div_q;
    logic               evt_q;
    logic [RC_W-1:0]    srst_cnt;
    logic               srst_act;
    logic               eng_busy, eng_done, run, rise, fall;
    logic               frame_ok, start_go;
    logic [DATA_W-1:0]  rd_data;

    assign srst_act = (srst_cnt != '0);
    assign frame_ok = reg_wr && reg_addr == ADDR_FRAME && !eng_busy && !srst_act;
    assign start_go = frame_ok && (div_q != '0);
    assign run      = eng_busy && !srst_act;

    // Soft reset counter: loads on a control write, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) srst_cnt <= '0;
        else if (srst_act) srst_cnt <= srst_cnt - 1'b1;
        else if (reg_wr && reg_addr == ADDR_CTRL && reg_wdata[0]) srst_cnt <= RC_W'(RST_LEN);
    end

    // Frame register: software load when idle, read data merge on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_act) frame_q <= '0;
        else if (frame_ok) frame_q <= reg_wdata;
        else if (eng_done && frame_q[29:28] == OP_READ) frame_q[DATA_W-1:0] <= rd_data;
    end

    // Speed register: divider field, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_act) div_q <= '0;
        else if (reg_wr && reg_addr == ADDR_SPEED && !eng_busy) div_q <= reg_wdata[DIV_W:1];
    end

    // Event register: set on completion (set wins), write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_act) evt_q <= 1'b0;
        else if (eng_done) evt_q <= 1'b1;
        else if (reg_wr && reg_addr == ADDR_EVT && reg_wdata[0]) evt_q <= 1'b0;
    end

    // Read-back multiplexer.
    always_comb begin
        case (reg_addr)
            ADDR_CTRL:  reg_rdata = {30'd0, eng_busy, srst_act};
            ADDR_EVT:   reg_rdata = {31'd0, evt_q};
            ADDR_SPEED: reg_rdata = 32'({div_q, 1'b0});
            default:    reg_rdata = frame_q;
        endcase
    end

    mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div_q),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_frame_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .abort(srst_act), .start(start_go),
        .frame_in(reg_wdata), .rise(rise), .fall(fall), .mdio_i(mdio_i),
        .busy(eng_busy), .done(eng_done), .rd_data(rd_data),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // R2: MDC is low whenever no frame is running.
    a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mdc);
    // R3: MDIO output holds steady while MDC stays high.
    a_r3_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
    // R5: a finished frame raises the event bit on the next clock.
    a_r5_done_sets_event: assert property (@(posedge clk) disable iff (!rst_n || srst_act)
        eng_done |=> evt_q);
    // R6: the frame register does not move while a frame is running.
    a_r6_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && $past(eng_busy)) |-> $stable(frame_q));
    // R7: a zero divider never has a frame in flight.
    a_r7_zero_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) |-> !eng_busy);
    // R8: when the soft reset ends, no frame is running.
    a_r8_reset_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_act) |-> !eng_busy);
endmodule

// File: tb/mdio_mgmt_engine_test.sv
// Directed bench for mdio_mgmt_engine with a behavioural PHY on MDC/MDIO.
module mdio_mgmt_engine_test;
    localparam int    RST_LEN = 4;
    localparam time   TCLK    = 5ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural PHY state
    int          rises = 0;
    int          base = 0;
    bit          cap_o  [0:4095];
    bit          cap_oe [0:4095];
    time         t_prev = 0, t_last = 0;
    logic [15:0] phy_data = 16'h0000;

    always #(TCLK/2) clk = ~clk;

    mdio_mgmt_engine #(.DIV_W(6), .RST_LEN(RST_LEN)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY: record what the master presents at each MDC rising edge.
    always @(posedge mdc) begin
        cap_o[rises % 4096]  = mdio_o;
        cap_oe[rises % 4096] = mdio_oe;
        t_prev = t_last;
        t_last = $time;
        rises  = rises + 1;
    end

    function automatic logic phy_bit(input int rel, input logic [15:0] d);
        if (rel >= 48 && rel < 64) return d[63 - rel];
        return 1'b1;
    endfunction
    assign mdio_i = phy_bit(rises - base, phy_data);

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int k = 0; k < 20000; k++) begin
            rd(2'd0, c);
            if (c[1] == 1'b0) break;
        end
        repeat (2) @(negedge clk);
    endtask

    function automatic logic exp_bit(input int i, input logic [31:0] f);
        if (i < 32) return 1'b1;
        return f[63 - i];
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1", "register after reset", v, 32'h0);
        end
        check("R1", "mdc after reset", {31'd0, mdc}, 32'h0);
        check("R1", "mdio_oe after reset", {31'd0, mdio_oe}, 32'h0);
    endtask

    task automatic t_zero_div();
        logic [31:0] v;
        int r0;
        r0 = rises;
        wr(2'd3, 32'h5082_1234);
        repeat (100) @(negedge clk);
        check("R7", "mdc edges with zero divider", 32'(rises - r0), 32'h0);
        rd(2'd0, v);
        check("R7", "busy with zero divider", {31'd0, v[1]}, 32'h0);
        rd(2'd3, v);
        check("R7", "frame word stored", v, 32'h5082_1234);
        rd(2'd1, v);
        check("R7", "no event", v, 32'h0);
    endtask

    task automatic t_write_frame();
        logic [31:0] v, f;
        int bad_o, bad_oe;
        f = 32'h5002_0000 | (32'd5 << 23) | (32'h11 << 18) | 32'hBEEF;
        wr(2'd2, 32'd3 << 1);
        rd(2'd2, v);
        check("R2", "speed readback", v, 32'd6);
        base = rises;
        wr(2'd3, f);
        rd(2'd0, v);
        check("R6", "busy during frame", {31'd0, v[1]}, 32'h1);
        wr(2'd3, 32'h1234_5678);
        wr(2'd2, 32'd9 << 1);
        rd(2'd3, v);
        check("R6", "frame write ignored while busy", v, f);
        rd(2'd2, v);
        check("R6", "speed write ignored while busy", v, 32'd6);
        wait_idle();
        check("R3", "MDC periods per write frame", 32'(rises - base), 32'd64);
        bad_o = 0; bad_oe = 0;
        for (int i = 0; i < 64; i++) begin
            if (cap_o[(base + i) % 4096] !== exp_bit(i, f)) bad_o++;
            if (cap_oe[(base + i) % 4096] !== 1'b1) bad_oe++;
        end
        check("R3", "write frame bit mismatches", 32'(bad_o), 32'h0);
        check("R3", "write frame released bits", 32'(bad_oe), 32'h0);
        check("R2", "MDC period ns at field 3", 32'((t_last - t_prev) / 1ns), 32'd30);
        check("R2", "mdc low after frame", {31'd0, mdc}, 32'h0);
        rd(2'd1, v);
        check("R5", "event after write frame", v, 32'h1);
        wr(2'd1, 32'h0);
        rd(2'd1, v);
        check("R5", "event kept on write of 0", v, 32'h1);
        wr(2'd1, 32'h1);
        rd(2'd1, v);
        check("R5", "event cleared by write of 1", v, 32'h0);
    endtask

    task automatic t_read_frame(input int field, input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
        logic [31:0] v, f;
        int bad_o, bad_oe;
        f = 32'h6002_0000 | (32'(pa) << 23) | (32'(ra) << 18);
        wr(2'd2, 32'(field) << 1);
        phy_data = d;
        base = rises;
        wr(2'd3, f);
        wait_idle();
        bad_o = 0; bad_oe = 0;
        for (int i = 0; i < 64; i++) begin
            if (i < 46) begin
                if (cap_oe[(base + i) % 4096] !== 1'b1) bad_oe++;
                if (cap_o[(base + i) % 4096] !== exp_bit(i, f)) bad_o++;
            end else if (cap_oe[(base + i) % 4096] !== 1'b0) bad_oe++;
        end
        check("R4", "read frame drive errors", 32'(bad_o), 32'h0);
        check("R4", "read frame release errors", 32'(bad_oe), 32'h0);
        check("R2", "MDC period ns", 32'((t_last - t_prev) / 1ns), 32'(field * 10));
        rd(2'd3, v);
        check("R4", "frame after read", v, {f[31:16], d});
        rd(2'd1, v);
        check("R5", "event after read frame", v, 32'h1);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v);
        check("R9", "event after all-ones write", v, 32'h0);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        wr(2'd2, 32'd2 << 1);
        wr(2'd3, 32'h5002_0000 | 32'h00AA);
        repeat (50) @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h1;
        @(negedge clk);
        reg_wr = 1'b0;
        #1 v = reg_rdata;
        check("R8", "reset bit reads 1", {31'd0, v[0]}, 32'h1);
        repeat (RST_LEN + 1) @(negedge clk);
        #1 v = reg_rdata;
        check("R8", "control after soft reset", v, 32'h0);
        rd(2'd3, v);
        check("R8", "frame cleared", v, 32'h0);
        rd(2'd2, v);
        check("R8", "speed cleared", v, 32'h0);
        repeat (20) @(negedge clk);
        rd(2'd1, v);
        check("R8", "no event from aborted frame", v, 32'h0);
        check("R8", "mdc low after abort", {31'd0, mdc}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_zero_div();
        t_write_frame();
        t_read_frame(3, 5'h1F, 5'd2, 16'hA55A);
        t_read_frame(1, 5'h00, 5'd3, 16'h0001);
        t_soft_reset();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule